// File: doc/BRIEF.md
# Two-Level Virtual Address Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A requester hands it one translation at a time. Each request carries the virtual address, the kind of access (instruction fetch, data load or data store) and the current privilege. The walker reads page table entries (PTEs) over a simple memory port. It validates the leaf it finds, checks access rights against the privilege and the status controls, and returns the physical address with read, write and execute rights, or a fault.

Machine-mode accesses and the bare (translation off) setting bypass the table. When a leaf has its accessed bit clear, or a store hits a page whose dirty bit is clear, the walker updates the entry with an atomic compare-and-swap on the memory port. If another agent changed the entry in the meantime, the walker starts the walk again from the root. Caching of translations and physical memory protection belong to neighbouring blocks.

Top module: `pageWalker`

## Requirements
- R1: In bare mode, or when the effective privilege is machine, the response comes one cycle after acceptance. It carries physical address = zero-extended virtual address, no fault, read/write/execute all 1, and no memory request is made.
- R2: Privilege encoding is user=0, supervisor=1, machine=3. Access encoding is fetch=0, load=1, store=2. For a load or store at machine privilege with cfgMprv set, the effective privilege is cfgMpp. Fetches ignore cfgMprv.
- R3: The first PTE read is at (cfgRootPpn<<12) + VA[31:22]*4. After a pointer entry, the next read is at (pointer PPN<<12) + VA[21:12]*4. A PTE holds V,R,W,X,U,G,A,D in bits 0 to 7 and its PPN in bits 31:10.
- R4: An entry with V=0 faults. An entry with V=1 and R=W=X=0 is a pointer. A pointer found at the second level faults.
- R5: A leaf with W=1 and R=0 faults, with X either 0 or 1.
- R6: A leaf with U=1 faults unless the effective privilege is user, or it is supervisor with cfgSum=1 on a non-fetch access. A leaf with U=0 faults unless the effective privilege is supervisor.
- R7: A leaf at the first level whose PPN bits [9:0] are not zero faults.
- R8: A load needs R, or X with cfgMxr=1. A store needs W. A fetch needs X. Otherwise the translation faults.
- R9: On success with A=0, or with D=0 on a store, one compare-and-swap is issued at the PTE address. Its compare value is the entry read, and its new value is that entry with A set, plus D for stores. No compare-and-swap is issued when no update is needed or when the translation faults.
- R10: If the compare-and-swap returns a value other than its compare value, the walk restarts at the root and re-reads both levels.
- R11: A second-level leaf gives physical address {PPN, VA[11:0]}. A first-level leaf gives {PPN[21:10], VA[21:12], VA[11:0]}.
- R12: The returned rights are read = R or (X and cfgMxr), execute = X, and write = W and (store or D). A fault returns all rights and the address as 0.
- R13: An error response to a PTE read or to a compare-and-swap faults the translation.
- R14: reqReady is high only when idle. Each accepted request yields exactly one single-cycle respValid pulse, and reqReady returns the cycle after it. Reset leaves reqReady=1, respValid=0, memReqValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 0 fetch, 1 load, 2 store |
| reqPriv | input | 2 | 0 user, 1 supervisor, 3 machine |
| cfgBare | input | 1 | Translation disabled |
| cfgRootPpn | input | 22 | Root table page number |
| cfgSum | input | 1 | Supervisor may touch user pages |
| cfgMxr | input | 1 | Executable pages readable |
| cfgMprv | input | 1 | Data accesses in machine mode use cfgMpp |
| cfgMpp | input | 2 | Substitute privilege for cfgMprv |
| memReqValid | output | 1 | Memory request strobe (one cycle) |
| memReqCas | output | 1 | 1 compare-and-swap, 0 read |
| memReqAddr | output | 34 | PTE byte address |
| memReqWdata | output | 32 | Swap value |
| memReqCmp | output | 32 | Compare value |
| memRspValid | input | 1 | Memory response strobe |
| memRspErr | input | 1 | Memory error |
| memRspData | input | 32 | Read data or old value |
| respValid | output | 1 | Translation done (one cycle) |
| respFault | output | 1 | Translation failed |
| respPaddr | output | 34 | Physical address |
| respRead | output | 1 | Read right |
| respWrite | output | 1 | Write right |
| respExec | output | 1 | Execute right |

## Verification
Pointer-then-leaf walks check the two read addresses and the 4 KiB address assembly. A first-level leaf with aligned and misaligned page numbers separates superpage composition from the alignment fault. Leaves with each rights mix are tried at user and supervisor privilege, and with cfgSum, cfgMxr and cfgMprv toggled. This shows which rule rejects which access and that fetches ignore the substitutions. Entries with A and D clear, half set or fully set tell apart when the compare-and-swap happens and what it writes. A memory model that alters the entry just before the swap, or returns an error, exposes the restart and the error fault.

// File: rtl/pageWalkerPkg.sv
package pageWalkerPkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int LEVELS  = 2;
  localparam int PTE_W   = 32;
  localparam int PPN_W   = 22;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int PTE_SH  = $clog2(PTE_W / 8);
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int VPN_W   = VA_W - OFF_W;

  // PTE flag positions
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic capture;
    logic bypass;
    logic loadPte;
    logic descend;
    logic restart;
    logic setFault;
    logic setLeaf;
  } strobeS;

  typedef struct packed {
    logic isBypass;
    logic pteBad;
    logic ptePointer;
    logic needUpdate;
    logic casMatch;
  } statusS;
endpackage

// File: rtl/pageWalkerDp.sv
module pageWalkerDp
  import pageWalkerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeS           strb,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic [1:0]       reqPriv,
  input  logic             cfgBare,
  input  logic [PPN_W-1:0] cfgRootPpn,
  input  logic             cfgSum,
  input  logic             cfgMxr,
  input  logic             cfgMprv,
  input  logic [1:0]       cfgMpp,
  input  logic [PTE_W-1:0] memRspData,
  output statusS           stat,
  output logic [PA_W-1:0]  memReqAddr,
  output logic [PTE_W-1:0] memReqWdata,
  output logic [PTE_W-1:0] memReqCmp,
  output logic             respFault,
  output logic [PA_W-1:0]  respPaddr,
  output logic             respRead,
  output logic             respWrite,
  output logic             respExec
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  logic [VA_W-1:0]  vaQ;
  logic [1:0]       accQ;
  logic [1:0]       privQ;
  logic             sumQ, mxrQ;
  logic [PPN_W-1:0] rootQ, baseQ;
  logic [LVL_W-1:0] lvlQ;
  logic [PTE_W-1:0] pteQ;
  logic             faultQ, rQ, wQ, xQ;
  logic [PA_W-1:0]  paQ;

  logic [1:0]       effPriv;
  logic             pV, pR, pW, pX, pU, pA, pD;
  logic             isFetch, isStore, isLoad, ptrEnc, lastLevel, leafBad;
  logic [PPN_W-1:0] ppn, lowMask, leafPpn;
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;

  // privilege substitution for data accesses
  always_comb begin
    effPriv = reqPriv;
    if (reqPriv == PRIV_M && reqAccess != ACC_FETCH && cfgMprv)
      effPriv = cfgMpp;
  end

  assign pV = pteQ[B_V];
  assign pR = pteQ[B_R];
  assign pW = pteQ[B_W];
  assign pX = pteQ[B_X];
  assign pU = pteQ[B_U];
  assign pA = pteQ[B_A];
  assign pD = pteQ[B_D];
  assign ppn = pteQ[PTE_W-1 -: PPN_W];
  assign vpn = vaQ[VA_W-1:OFF_W];

  assign isFetch   = (accQ == ACC_FETCH);
  assign isStore   = (accQ == ACC_STORE);
  assign isLoad    = !isFetch && !isStore;
  assign ptrEnc    = !pR && !pW && !pX;
  assign lastLevel = (lvlQ == '0);
  assign lowMask   = ~({PPN_W{1'b1}} << (IDX_W * int'(lvlQ)));

  always_comb begin
    leafBad = 1'b0;
    if (pW && !pR) leafBad = 1'b1;
    if (pU && privQ != PRIV_U && (!sumQ || isFetch)) leafBad = 1'b1;
    if (!pU && privQ != PRIV_S) leafBad = 1'b1;
    if ((ppn & lowMask) != '0) leafBad = 1'b1;
    if (isLoad && !(pR || (pX && mxrQ))) leafBad = 1'b1;
    if (isStore && !pW) leafBad = 1'b1;
    if (isFetch && !pX) leafBad = 1'b1;
  end

  assign stat.isBypass   = cfgBare || (effPriv == PRIV_M);
  assign stat.ptePointer = pV && ptrEnc;
  assign stat.pteBad     = !pV || (ptrEnc ? lastLevel : leafBad);
  assign stat.needUpdate = !pA || (isStore && !pD);
  assign stat.casMatch   = (memRspData == pteQ);

  assign idx         = vaQ[OFF_W + IDX_W * int'(lvlQ) +: IDX_W];
  assign memReqAddr  = {baseQ, idx, {PTE_SH{1'b0}}};
  assign memReqCmp   = pteQ;
  assign memReqWdata = pteQ | (PTE_W'(1) << B_A) | (isStore ? (PTE_W'(1) << B_D) : '0);

  assign leafPpn = (ppn & ~lowMask) | (PPN_W'(vpn) & lowMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ <= '0; accQ <= '0; privQ <= '0; sumQ <= 1'b0; mxrQ <= 1'b0;
      rootQ <= '0; baseQ <= '0; lvlQ <= '0; pteQ <= '0;
      faultQ <= 1'b0; paQ <= '0; rQ <= 1'b0; wQ <= 1'b0; xQ <= 1'b0;
    end else begin
      if (strb.capture) begin
        vaQ   <= reqVaddr;
        accQ  <= reqAccess;
        privQ <= effPriv;
        sumQ  <= cfgSum;
        mxrQ  <= cfgMxr;
        rootQ <= cfgRootPpn;
        baseQ <= cfgRootPpn;
        lvlQ  <= TOP_LVL;
      end
      if (strb.bypass) begin
        faultQ <= 1'b0;
        paQ    <= PA_W'(reqVaddr);
        rQ <= 1'b1; wQ <= 1'b1; xQ <= 1'b1;
      end
      if (strb.loadPte) pteQ <= memRspData;
      if (strb.descend) begin
        baseQ <= ppn;
        lvlQ  <= lvlQ - 1'b1;
      end
      if (strb.restart) begin
        baseQ <= rootQ;
        lvlQ  <= TOP_LVL;
      end
      if (strb.setFault) begin
        faultQ <= 1'b1;
        paQ    <= '0;
        rQ <= 1'b0; wQ <= 1'b0; xQ <= 1'b0;
      end
      if (strb.setLeaf) begin
        faultQ <= 1'b0;
        paQ    <= {leafPpn, vaQ[OFF_W-1:0]};
        rQ     <= pR || (pX && mxrQ);
        wQ     <= pW && (isStore || pD);
        xQ     <= pX;
      end
    end
  end

  assign respFault = faultQ;
  assign respPaddr = paQ;
  assign respRead  = rQ;
  assign respWrite = wQ;
  assign respExec  = xQ;

  // R11
  leaf_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setLeaf |=> (respPaddr[OFF_W-1:0] == vaQ[OFF_W-1:0]));
endmodule

// File: rtl/pageWalkerCtrl.sv
module pageWalkerCtrl
  import pageWalkerPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  statusS stat,
  input  logic   memRspValid,
  input  logic   memRspErr,
  output strobeS strb,
  output logic   reqReady,
  output logic   memReqValid,
  output logic   memReqCas,
  output logic   respValid
);
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE_RD, S_WAIT_RD, S_EVAL, S_ISSUE_CAS, S_WAIT_CAS, S_RESP
  } stateE;

  stateE state, nextState;

  always_comb begin
    nextState = state;
    strb = '0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strb.capture = 1'b1;
        if (stat.isBypass) begin
          strb.bypass = 1'b1;
          nextState = S_RESP;
        end else begin
          nextState = S_ISSUE_RD;
        end
      end
      S_ISSUE_RD: nextState = S_WAIT_RD;
      S_WAIT_RD: if (memRspValid) begin
        if (memRspErr) begin
          strb.setFault = 1'b1;
          nextState = S_RESP;
        end else begin
          strb.loadPte = 1'b1;
          nextState = S_EVAL;
        end
      end
      S_EVAL: begin
        if (stat.pteBad) begin
          strb.setFault = 1'b1;
          nextState = S_RESP;
        end else if (stat.ptePointer) begin
          strb.descend = 1'b1;
          nextState = S_ISSUE_RD;
        end else if (stat.needUpdate) begin
          nextState = S_ISSUE_CAS;
        end else begin
          strb.setLeaf = 1'b1;
          nextState = S_RESP;
        end
      end
      S_ISSUE_CAS: nextState = S_WAIT_CAS;
      S_WAIT_CAS: if (memRspValid) begin
        if (memRspErr) begin
          strb.setFault = 1'b1;
          nextState = S_RESP;
        end else if (stat.casMatch) begin
          strb.setLeaf = 1'b1;
          nextState = S_RESP;
        end else begin
          strb.restart = 1'b1;
          nextState = S_ISSUE_RD;
        end
      end
      S_RESP: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE_RD) || (state == S_ISSUE_CAS);
  assign memReqCas   = (state == S_ISSUE_CAS);
  assign respValid   = (state == S_RESP);

  // R14
  resp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (reqReady && !respValid));

  // R13
  read_err_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_RD && memRspValid && memRspErr) |=> respValid);

  // R10
  cas_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_CAS && memRspValid && !memRspErr && !stat.casMatch)
      |=> (memReqValid && !memReqCas));
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import pageWalkerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic [1:0]       reqPriv,
  input  logic             cfgBare,
  input  logic [PPN_W-1:0] cfgRootPpn,
  input  logic             cfgSum,
  input  logic             cfgMxr,
  input  logic             cfgMprv,
  input  logic [1:0]       cfgMpp,
  output logic             memReqValid,
  output logic             memReqCas,
  output logic [PA_W-1:0]  memReqAddr,
  output logic [PTE_W-1:0] memReqWdata,
  output logic [PTE_W-1:0] memReqCmp,
  input  logic             memRspValid,
  input  logic             memRspErr,
  input  logic [PTE_W-1:0] memRspData,
  output logic             respValid,
  output logic             respFault,
  output logic [PA_W-1:0]  respPaddr,
  output logic             respRead,
  output logic             respWrite,
  output logic             respExec
);
  strobeS strb;
  statusS stat;

  pageWalkerCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .strb(strb),
    .reqReady(reqReady), .memReqValid(memReqValid), .memReqCas(memReqCas),
    .respValid(respValid)
  );

  pageWalkerDp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqPriv(reqPriv), .cfgBare(cfgBare),
    .cfgRootPpn(cfgRootPpn), .cfgSum(cfgSum), .cfgMxr(cfgMxr),
    .cfgMprv(cfgMprv), .cfgMpp(cfgMpp), .memRspData(memRspData),
    .stat(stat), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memReqCmp(memReqCmp), .respFault(respFault), .respPaddr(respPaddr),
    .respRead(respRead), .respWrite(respWrite), .respExec(respExec)
  );

  // R1
  bare_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && cfgBare)
      |=> (respValid && !respFault && respRead && respWrite && respExec));

  // R9
  cas_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqCas)
      |-> (memReqWdata[B_A] && ((memReqWdata & memReqCmp) == memReqCmp)));

  // R13
  err_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(memRspValid && memRspErr)) |-> respFault);

  // R14
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: tb/tb_pageWalker.sv
`timescale 1ns/1ps
module tb_pageWalker;
  localparam logic [9:0] FV = 10'h001, FR = 10'h002, FW = 10'h004, FX = 10'h008;
  localparam logic [9:0] FU = 10'h010, FG = 10'h020, FA = 10'h040, FD = 10'h080;
  localparam logic [1:0] AF = 2'd0, AL = 2'd1, AS = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0] reqAccess = '0, reqPriv = '0;
  logic cfgBare = 1'b0, cfgSum = 1'b0, cfgMxr = 1'b0, cfgMprv = 1'b0;
  logic [21:0] cfgRootPpn = 22'h100;
  logic [1:0] cfgMpp = '0;
  logic memReqValid, memReqCas;
  logic [33:0] memReqAddr;
  logic [31:0] memReqWdata, memReqCmp;
  logic memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memRspData = '0;
  logic respValid, respFault, respRead, respWrite, respExec;
  logic [33:0] respPaddr;

  always #4 clk = ~clk;

  pageWalker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqPriv(reqPriv),
    .cfgBare(cfgBare), .cfgRootPpn(cfgRootPpn), .cfgSum(cfgSum),
    .cfgMxr(cfgMxr), .cfgMprv(cfgMprv), .cfgMpp(cfgMpp),
    .memReqValid(memReqValid), .memReqCas(memReqCas), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memReqCmp(memReqCmp),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .memRspData(memRspData),
    .respValid(respValid), .respFault(respFault), .respPaddr(respPaddr),
    .respRead(respRead), .respWrite(respWrite), .respExec(respExec)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] mem [logic [33:0]];

  int rdN, casN, busyBad;
  logic [33:0] rdAddr0, rdAddr1, casAddr;
  logic [31:0] casCmp, casWdata;
  logic gotFault, gotR, gotW, gotX;
  logic [33:0] gotPa;
  bit clobberArm = 0, errArm = 0, errCasArm = 0;
  logic [33:0] errAddr = '0;

  function automatic logic [31:0] memRd(input logic [33:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkPte(input logic [21:0] ppn, input logic [9:0] fl);
    return {ppn, fl};
  endfunction

  function automatic logic [31:0] va3(input logic [9:0] v1, input logic [9:0] v0,
                                      input logic [11:0] off);
    return {v1, v0, off};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drives one request and serves the memory port until the response
  task automatic xlate(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] pr);
    bit pend = 0;
    bit done = 0;
    logic [31:0] pData = '0;
    logic pErr = 1'b0;
    int guard = 0;
    rdN = 0; casN = 0;
    @(negedge clk);
    reqVaddr = va; reqAccess = acc; reqPriv = pr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) begin
      if (respValid) begin
        gotFault = respFault; gotPa = respPaddr;
        gotR = respRead; gotW = respWrite; gotX = respExec;
        done = 1;
      end else begin
        memRspValid = pend; memRspData = pData; memRspErr = pErr;
        pend = 0;
        if (memReqValid) begin
          if (reqReady) busyBad++;
          if (!memReqCas) begin
            rdN++;
            if (rdN == 1) rdAddr0 = memReqAddr;
            if (rdN == 2) rdAddr1 = memReqAddr;
            pErr = errArm && (memReqAddr == errAddr);
            if (pErr) errArm = 0;
            pData = memRd(memReqAddr);
          end else begin
            casN++;
            casAddr = memReqAddr; casCmp = memReqCmp; casWdata = memReqWdata;
            if (clobberArm) begin
              mem[memReqAddr] = memRd(memReqAddr) | 32'(FG);
              clobberArm = 0;
            end
            pErr = errCasArm;
            errCasArm = 0;
            pData = memRd(memReqAddr);
            if (!pErr && pData == memReqCmp) mem[memReqAddr] = memReqWdata;
          end
          pend = 1;
        end
        @(negedge clk);
        guard++;
        if (guard > 300) begin
          check("R14 response timeout", 64'd0, 64'd1);
          done = 1;
        end
      end
    end
    memRspValid = 1'b0; memRspErr = 1'b0;
  endtask

  task automatic testReset();
    check("R14 reset reqReady", 64'(reqReady), 64'd1);
    check("R14 reset respValid", 64'(respValid), 64'd0);
    check("R14 reset memReqValid", 64'(memReqValid), 64'd0);
  endtask

  task automatic testBypass();
    xlate(32'hDEADB123, AF, PM);
    check("R1 machine pa", 64'(gotPa), 64'h0DEADB123);
    check("R1 machine rights", 64'({gotFault, gotR, gotW, gotX}), 64'h7);
    check("R1 machine no reads", 64'(rdN), 64'd0);
    cfgBare = 1'b1;
    xlate(32'h00402345, AL, PU);
    check("R1 bare pa", 64'(gotPa), 64'h000402345);
    check("R1 bare rights", 64'({gotFault, gotR, gotW, gotX}), 64'h7);
    check("R1 bare no reads", 64'(rdN), 64'd0);
    cfgBare = 1'b0;
  endtask

  task automatic testWalk4k();
    busyBad = 0;
    xlate(va3(10'd1, 10'd2, 12'h345), AL, PS);
    check("R3 root read addr", 64'(rdAddr0), 64'h100004);
    check("R3 leaf read addr", 64'(rdAddr1), 64'h200008);
    check("R11 4K pa", 64'(gotPa), 64'h12345345);
    check("R12 rights RWX", 64'({gotFault, gotR, gotW, gotX}), 64'b0110);
    check("R9 no swap when A D set", 64'(casN), 64'd0);
    check("R14 not ready while busy", 64'(busyBad), 64'd0);
    check("R14 ready after resp", 64'(reqReady), 64'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R14 single response", 64'({respValid, reqReady}), 64'b01);
    end
  endtask

  task automatic testMprv();
    cfgMprv = 1'b1; cfgMpp = PS;
    xlate(va3(10'd1, 10'd2, 12'h010), AL, PM);
    check("R2 mprv load walks", 64'(rdN), 64'd2);
    check("R2 mprv load pa", 64'(gotPa), 64'h12345010);
    xlate(32'h00402010, AF, PM);
    check("R2 mprv fetch bypass", 64'(rdN), 64'd0);
    check("R2 mprv fetch pa", 64'(gotPa), 64'h00402010);
    cfgMprv = 1'b0; cfgMpp = PU;
  endtask

  task automatic testAccessed();
    logic [31:0] old6, old7;
    old6 = mkPte(22'h00abc, FV | FR | FW);
    mem[34'h200018] = old6;
    xlate(va3(10'd1, 10'd6, 12'h004), AS, PS);
    check("R9 store swap count", 64'(casN), 64'd1);
    check("R9 swap addr", 64'(casAddr), 64'h200018);
    check("R9 swap cmp", 64'(casCmp), 64'(old6));
    check("R9 swap value", 64'(casWdata), 64'(old6 | 32'(FA | FD)));
    check("R9 memory updated", 64'(memRd(34'h200018)), 64'(old6 | 32'(FA | FD)));
    check("R12 store write right", 64'({gotFault, gotW}), 64'b01);
    check("R11 store pa", 64'(gotPa), 64'h00abc004);
    xlate(va3(10'd1, 10'd6, 12'h008), AL, PS);
    check("R9 no swap second time", 64'(casN), 64'd0);
    check("R12 load write right with D", 64'(gotW), 64'd1);
    old7 = mkPte(22'h00abd, FV | FR | FW | FA);
    mem[34'h20001C] = old7;
    xlate(va3(10'd1, 10'd7, 12'h000), AL, PS);
    check("R9 load A set no swap", 64'(casN), 64'd0);
    check("R12 load without D", 64'({gotFault, gotR, gotW, gotX}), 64'b0100);
    xlate(va3(10'd1, 10'd7, 12'h000), AS, PS);
    check("R9 store sets D only", 64'(casWdata), 64'(old7 | 32'(FD)));
  endtask

  task automatic testSuper();
    mem[34'h10000C] = mkPte(22'h000C00, FV | FR | FX | FA);
    xlate(va3(10'd3, 10'h155, 12'hABC), AF, PS);
    check("R11 superpage pa", 64'(gotPa), 64'h000D55ABC);
    check("R11 superpage one read", 64'(rdN), 64'd1);
    check("R12 superpage rights", 64'({gotFault, gotR, gotW, gotX}), 64'b0101);
    mem[34'h100010] = mkPte(22'h000C01, FV | FR | FX | FA);
    xlate(va3(10'd4, 10'h155, 12'h000), AF, PS);
    check("R7 misaligned superpage", 64'(gotFault), 64'd1);
    check("R12 fault clears output", 64'({gotPa, gotR, gotW, gotX}), 64'd0);
  endtask

  task automatic testFaults();
    mem[34'h200020] = 32'h0;
    mem[34'h200024] = mkPte(22'h300, FV);
    mem[34'h200028] = mkPte(22'h301, FV | FW | FA);
    mem[34'h20002C] = mkPte(22'h302, FV | FW | FX | FA);
    mem[34'h200030] = mkPte(22'h303, FV | FR | FX | FU | FA);
    mem[34'h200034] = mkPte(22'h304, FV | FR | FA);
    mem[34'h200038] = mkPte(22'h305, FV | FX | FA);
    xlate(va3(10'd1, 10'd8, 12'h0), AL, PS);
    check("R4 invalid entry", 64'(gotFault), 64'd1);
    xlate(va3(10'd1, 10'd9, 12'h0), AL, PS);
    check("R4 pointer at last level", 64'({gotFault, 4'(rdN)}), 64'h12);
    xlate(va3(10'd1, 10'd10, 12'h0), AS, PS);
    check("R5 write-only leaf", 64'(gotFault), 64'd1);
    check("R9 no swap on fault", 64'(casN), 64'd0);
    xlate(va3(10'd1, 10'd11, 12'h0), AF, PS);
    check("R5 write-exec leaf", 64'(gotFault), 64'd1);
    xlate(va3(10'd1, 10'd12, 12'h0), AL, PS);
    check("R6 user page from sup no SUM", 64'(gotFault), 64'd1);
    cfgSum = 1'b1;
    xlate(va3(10'd1, 10'd12, 12'h0), AL, PS);
    check("R6 user page from sup SUM", 64'({gotFault, gotR}), 64'b01);
    xlate(va3(10'd1, 10'd12, 12'h0), AF, PS);
    check("R6 user page fetch with SUM", 64'(gotFault), 64'd1);
    cfgSum = 1'b0;
    xlate(va3(10'd1, 10'd12, 12'h0), AF, PU);
    check("R6 user page from user", 64'({gotFault, gotX}), 64'b01);
    xlate(va3(10'd1, 10'd13, 12'h0), AL, PU);
    check("R6 sup page from user", 64'(gotFault), 64'd1);
    xlate(va3(10'd1, 10'd14, 12'h0), AL, PS);
    check("R8 load exec-only no MXR", 64'(gotFault), 64'd1);
    cfgMxr = 1'b1;
    xlate(va3(10'd1, 10'd14, 12'h0), AL, PS);
    check("R8 load exec-only MXR", 64'({gotFault, gotR, gotX}), 64'b011);
    cfgMxr = 1'b0;
    xlate(va3(10'd1, 10'd14, 12'h0), AS, PS);
    check("R8 store exec-only", 64'(gotFault), 64'd1);
    xlate(va3(10'd1, 10'd13, 12'h0), AF, PS);
    check("R8 fetch read-only", 64'(gotFault), 64'd1);
  endtask

  task automatic testRestart();
    logic [31:0] old;
    old = mkPte(22'h04444, FV | FR | FW);
    mem[34'h200040] = old;
    clobberArm = 1;
    xlate(va3(10'd1, 10'd16, 12'h111), AL, PS);
    check("R10 reads after restart", 64'(rdN), 64'd4);
    check("R10 swaps after restart", 64'(casN), 64'd2);
    check("R10 second swap cmp", 64'(casCmp), 64'(old | 32'(FG)));
    check("R10 final memory", 64'(memRd(34'h200040)), 64'(old | 32'(FG | FA)));
    check("R10 result", 64'({gotFault, gotPa}), 64'h004444111);
  endtask

  task automatic testMemErr();
    errArm = 1; errAddr = 34'h100004;
    xlate(va3(10'd1, 10'd2, 12'h0), AL, PS);
    check("R13 read error faults", 64'({gotFault, 4'(rdN)}), 64'h11);
    mem[34'h200044] = mkPte(22'h04445, FV | FR);
    errCasArm = 1;
    xlate(va3(10'd1, 10'd17, 12'h0), AL, PS);
    check("R13 swap error faults", 64'({gotFault, 4'(casN)}), 64'h11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    mem[34'h100004] = mkPte(22'h200, FV);
    mem[34'h200008] = mkPte(22'h12345, FV | FR | FW | FA | FD);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBypass();
    testWalk4k();
    testMprv();
    testAccessed();
    testSuper();
    testFaults();
    testRestart();
    testMemErr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule